// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block takes a CAN frame that the bit-level engine has already decoded and decides which of fifteen message objects accepts it. Each object carries an identifier, a frame-type flag, a direction bit and a valid bit. A single global mask chooses which identifier bits take part in the comparison, for standard and extended frames alike. The final object can only receive. It applies a second mask of its own on top of the global one, so a whole group of identifiers can land in it.

When an object accepts a frame, the length code and the payload bytes covered by that code are written into the object's storage, and its new-data flag is raised. If that flag was still set, the message-lost flag is raised as well. A one-cycle receive interrupt announces the store. A host configures the objects and masks through a narrow write port and can clear the flags through it. A read port returns any object's stored length code and payload one cycle after the request.

Top module: `can_rx_filter`

## Requirements
- R1: Synchronous reset has these effects: all new-data and message-lost flags go to 0, hit and rx_irq go low, hit_idx goes to 0, every object becomes invalid, both masks become all ones, objects 0 to 13 become transmit-directed and object 14 becomes receive-directed.
- R2: An object with index k matches only if all of these hold: it is valid, it is receive-directed, its extended flag equals frm_ext, and every identifier bit whose mask bit is 1 is equal. A mask bit of 0 is don't care. Configuration writes use cfg_sel=0 to write the identifier (cfg_wdata[28:0]) and cfg_sel=1 to write control: bit 0 is valid, bit 1 is receive direction, bit 2 is extended. cfg_sel=2 writes the global mask.
- R3: For a standard frame (frm_ext=0), only identifier bits [28:18] are compared. The standard identifier sits in those bits and bits [17:0] are ignored.
- R4: When several objects match, the lowest index wins. Object 14 is accepted only when none of objects 0 to 13 match.
- R5: Object 14 is always receive-directed, and the direction bit of a control write to it is ignored. Its effective mask is the AND of the global mask and its own mask, which cfg_sel=3 writes.
- R6: On acceptance, object k stores frm_dlc and the payload bytes 0 to min(dlc,8)-1, where byte i is frm_data[8i+7:8i]. Stored bytes at higher positions keep their old values, and new_data[k] is set.
- R7: If new_data[k] is already set when object k stores a frame, msg_lost[k] is set.
- R8: hit and rx_irq are high for exactly the one cycle that lies two clock edges after the edge that samples frm_valid, and hit_idx then shows the accepting object. Frames on consecutive cycles give consecutive pulses.
- R9: A frame that no object matches changes no flag, no stored data and no output. hit stays low.
- R10: A write with cfg_sel=4 to object k clears new_data[k] if cfg_wdata[0]=1 and clears msg_lost[k] if cfg_wdata[1]=1. The cleared flags are visible after the next clock edge.
- R11: rd_dlc and rd_data show the stored length code and payload of object rd_obj after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_obj | input | 4 | Object addressed by the write |
| cfg_wdata | input | 29 | Configuration write data |
| frm_valid | input | 1 | Decoded frame present this cycle |
| frm_id | input | 29 | Frame identifier; a standard identifier sits in bits [28:18] |
| frm_ext | input | 1 | Frame uses an extended identifier |
| frm_dlc | input | 4 | Frame data length code |
| frm_data | input | 64 | Frame payload, byte i in bits [8i+7:8i] |
| rd_obj | input | 4 | Object selected for read-back |
| rd_dlc | output | 4 | Stored length code of the selected object |
| rd_data | output | 64 | Stored payload of the selected object |
| hit | output | 1 | One-cycle acceptance pulse |
| hit_idx | output | 4 | Index of the last accepting object |
| rx_irq | output | 1 | One-cycle receive interrupt |
| new_data | output | 15 | Per-object new-data flags |
| msg_lost | output | 15 | Per-object message-lost flags |

## Verification
The bench builds the block with its default parameters: fifteen objects with eight payload bytes each. This puts the special last object at index 14 and lets a length code above eight check that the store is clamped to the full payload width. With these values the bench can run priority contests between low objects and the group-masked last object, apply masks that differ between the global and the group levels, and send frames back to back through the two-stage decision path.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int DLC_W = 4;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_ID    = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_GMASK = 3'd2,
    SEL_LMASK = 3'd3,
    SEL_CLR   = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic            vld;
    logic            rx;
    logic            ext;
    logic [ID_W-1:0] id;
  } obj_cfg_t;
endpackage

// File: rtl/can_rx_cfg.sv
module can_rx_cfg
  import can_rx_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int IDX_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [SEL_W-1:0]        sel,
  input  logic [IDX_W-1:0]        obj,
  input  logic [ID_W-1:0]         wdata,
  output obj_cfg_t [NUM_OBJ-1:0]  cfg_o,
  output logic [ID_W-1:0]         gmask_o,
  output logic [ID_W-1:0]         lmask_o,
  output logic [NUM_OBJ-1:0]      clr_nd_o,
  output logic [NUM_OBJ-1:0]      clr_lost_o
);

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    localparam logic IS_LAST = (g == NUM_OBJ - 1);
    obj_cfg_t q;
    logic     sel_me;

    assign sel_me = we && (obj == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q.vld <= 1'b0;
        q.rx  <= IS_LAST;
        q.ext <= 1'b0;
        q.id  <= '0;
      end else if (sel_me) begin
        if (sel == SEL_ID) q.id <= wdata;
        if (sel == SEL_CTRL) begin
          q.vld <= wdata[0];
          q.rx  <= IS_LAST ? 1'b1 : wdata[1];
          q.ext <= wdata[2];
        end
      end
    end

    assign cfg_o[g]      = q;
    assign clr_nd_o[g]   = sel_me && (sel == SEL_CLR) && wdata[0];
    assign clr_lost_o[g] = sel_me && (sel == SEL_CLR) && wdata[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_o <= '1;
      lmask_o <= '1;
    end else if (we) begin
      if (sel == SEL_GMASK) gmask_o <= wdata;
      if (sel == SEL_LMASK) lmask_o <= wdata;
    end
  end

endmodule

// File: rtl/can_rx_match.sv
module can_rx_match
  import can_rx_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input  obj_cfg_t [NUM_OBJ-1:0] cfg_i,
  input  logic [ID_W-1:0]        gmask_i,
  input  logic [ID_W-1:0]        lmask_i,
  input  logic [ID_W-1:0]        frm_id_i,
  input  logic                   frm_ext_i,
  output logic [NUM_OBJ-1:0]     match_o
);

  localparam logic [ID_W-1:0] STD_SEL = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
    logic [ID_W-1:0] own_m;
    logic [ID_W-1:0] cmp_m;

    if (g == NUM_OBJ - 1) begin : g_group
      assign own_m = gmask_i & lmask_i;
    end else begin : g_plain
      assign own_m = gmask_i;
    end

    assign cmp_m      = frm_ext_i ? own_m : (own_m & STD_SEL);
    assign match_o[g] = cfg_i[g].vld && cfg_i[g].rx &&
                        (cfg_i[g].ext == frm_ext_i) &&
                        (((cfg_i[g].id ^ frm_id_i) & cmp_m) == '0);
  end

endmodule

// File: rtl/can_rx_prio.sv
module can_rx_prio #(
  parameter int N     = 15,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/can_rx_store.sv
module can_rx_store
  import can_rx_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int BYTE_N  = 8,
  parameter int IDX_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DLC_W-1:0]      wr_dlc,
  input  logic [BYTE_N*8-1:0]   wr_data,
  input  logic [NUM_OBJ-1:0]    clr_nd,
  input  logic [NUM_OBJ-1:0]    clr_lost,
  input  logic [IDX_W-1:0]      rd_obj,
  output logic [DLC_W-1:0]      rd_dlc,
  output logic [BYTE_N*8-1:0]   rd_data,
  output logic [NUM_OBJ-1:0]    new_data,
  output logic [NUM_OBJ-1:0]    msg_lost
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OBJ - 1);

  logic [BYTE_N-1:0][7:0] mem_q [NUM_OBJ];
  logic [DLC_W-1:0]       dlc_q [NUM_OBJ];
  logic [BYTE_N-1:0]      be;
  logic [NUM_OBJ-1:0]     set_v;

  always_comb begin
    for (int b = 0; b < BYTE_N; b++) begin
      be[b] = (32'(wr_dlc) > b);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTE_N; b++) begin
        if (be[b]) mem_q[wr_idx][b] <= wr_data[8*b +: 8];
      end
      dlc_q[wr_idx] <= wr_dlc;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_obj <= LAST) begin
      rd_data <= mem_q[rd_obj];
      rd_dlc  <= dlc_q[rd_obj];
    end
  end

  assign set_v = wr_en ? (NUM_OBJ'(1) << wr_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      new_data <= '0;
      msg_lost <= '0;
    end else begin
      new_data <= (new_data & ~clr_nd) | set_v;
      msg_lost <= (msg_lost & ~clr_lost) | (set_v & new_data);
    end
  end

endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter
  import can_rx_pkg::*;
#(
  parameter int  NUM_OBJ = 15,
  parameter int  BYTE_N  = 8,
  localparam int IDX_W   = $clog2(NUM_OBJ),
  localparam int DATA_W  = 8 * BYTE_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [IDX_W-1:0]   cfg_obj,
  input  logic [ID_W-1:0]    cfg_wdata,
  input  logic               frm_valid,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_ext,
  input  logic [DLC_W-1:0]   frm_dlc,
  input  logic [DATA_W-1:0]  frm_data,
  input  logic [IDX_W-1:0]   rd_obj,
  output logic [DLC_W-1:0]   rd_dlc,
  output logic [DATA_W-1:0]  rd_data,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               rx_irq,
  output logic [NUM_OBJ-1:0] new_data,
  output logic [NUM_OBJ-1:0] msg_lost
);

  obj_cfg_t [NUM_OBJ-1:0] cfg_q;
  logic [ID_W-1:0]        gmask, lmask;
  logic [NUM_OBJ-1:0]     clr_nd, clr_lost, match_v;
  logic                   found;
  logic [IDX_W-1:0]       win_idx;

  // first stage: registered decision and captured frame
  logic                   s1_vld;
  logic [IDX_W-1:0]       s1_idx;
  logic [DLC_W-1:0]       s1_dlc;
  logic [DATA_W-1:0]      s1_data;

  can_rx_cfg #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .obj(cfg_obj),
    .wdata(cfg_wdata), .cfg_o(cfg_q), .gmask_o(gmask), .lmask_o(lmask),
    .clr_nd_o(clr_nd), .clr_lost_o(clr_lost)
  );

  can_rx_match #(.NUM_OBJ(NUM_OBJ)) u_match (
    .cfg_i(cfg_q), .gmask_i(gmask), .lmask_i(lmask),
    .frm_id_i(frm_id), .frm_ext_i(frm_ext), .match_o(match_v)
  );

  can_rx_prio #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_prio (
    .req(match_v), .found(found), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= frm_valid && found;
    end
  end

  always_ff @(posedge clk) begin
    if (frm_valid) begin
      s1_idx  <= win_idx;
      s1_dlc  <= frm_dlc;
      s1_data <= frm_data;
    end
  end

  can_rx_store #(.NUM_OBJ(NUM_OBJ), .BYTE_N(BYTE_N), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(s1_vld), .wr_idx(s1_idx), .wr_dlc(s1_dlc),
    .wr_data(s1_data), .clr_nd(clr_nd), .clr_lost(clr_lost),
    .rd_obj(rd_obj), .rd_dlc(rd_dlc), .rd_data(rd_data),
    .new_data(new_data), .msg_lost(msg_lost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      rx_irq  <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit    <= s1_vld;
      rx_irq <= s1_vld;
      if (s1_vld) hit_idx <= s1_idx;
    end
  end

endmodule

// File: rtl/can_rx_filter_chk.sv
module can_rx_filter_chk #(
  parameter int NUM_OBJ = 15,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               frm_valid,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic               rx_irq,
  input logic [NUM_OBJ-1:0] new_data,
  input logic [NUM_OBJ-1:0] msg_lost
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (new_data == '0 && msg_lost == '0 && !hit && !rx_irq));

  // R8
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (hit || rx_irq) |-> $past(frm_valid, 2));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (32'(hit_idx) < NUM_OBJ));

  // R6
  nd_with_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> new_data[hit_idx]);

  // R6
  nd_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((new_data & ~$past(new_data)) != '0) |-> hit);

  // R7
  lost_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((msg_lost & ~$past(msg_lost) & ~$past(new_data)) == '0));

endmodule

bind can_rx_filter can_rx_filter_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .hit(hit), .hit_idx(hit_idx),
  .rx_irq(rx_irq), .new_data(new_data), .msg_lost(msg_lost)
);

// File: tb/can_rx_filter_bench.sv
module can_rx_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 15;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [3:0]  cfg_obj;
  logic [28:0] cfg_wdata;
  logic        frm_valid;
  logic [28:0] frm_id;
  logic        frm_ext;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic [3:0]  rd_obj;
  logic [3:0]  rd_dlc;
  logic [63:0] rd_data;
  logic        hit;
  logic [3:0]  hit_idx;
  logic        rx_irq;
  logic [14:0] new_data;
  logic [14:0] msg_lost;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_filter u_can_rx_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_obj(cfg_obj),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_ext(frm_ext), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .rd_obj(rd_obj), .rd_dlc(rd_dlc), .rd_data(rd_data), .hit(hit),
    .hit_idx(hit_idx), .rx_irq(rx_irq), .new_data(new_data), .msg_lost(msg_lost)
  );

  // behavioural reference model
  logic [28:0] m_id [NOBJ];
  bit          m_vld [NOBJ];
  bit          m_rx [NOBJ];
  bit          m_ext [NOBJ];
  logic [28:0] m_gm, m_lm;
  logic [14:0] m_nd, m_lost;
  logic [63:0] m_mem [NOBJ];
  logic [63:0] m_kn [NOBJ];
  logic [3:0]  m_dlc [NOBJ];
  bit          m_hit;
  int          m_idx;
  bit          p_vld;
  int          p_idx;
  logic [3:0]  p_dlc;
  logic [63:0] p_data;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NOBJ; i++) begin
        m_id[i] = '0; m_vld[i] = 0; m_rx[i] = (i == NOBJ - 1); m_ext[i] = 0;
        m_kn[i] = '0; m_mem[i] = '0; m_dlc[i] = '0;
      end
      m_gm = '1; m_lm = '1; m_nd = '0; m_lost = '0;
      m_hit = 0; m_idx = 0; p_vld = 0; p_idx = 0;
    end else begin
      logic [14:0] nd_old, setv, cn, cl;
      nd_old = m_nd; setv = '0; cn = '0; cl = '0; m_hit = 0;
      if (p_vld) begin
        setv[p_idx] = 1'b1;
        for (int b = 0; b < 8; b++) begin
          if (b < int'(p_dlc)) begin
            m_mem[p_idx][8*b +: 8] = p_data[8*b +: 8];
            m_kn[p_idx][8*b +: 8]  = 8'hFF;
          end
        end
        m_dlc[p_idx] = p_dlc;
        m_hit = 1; m_idx = p_idx;
      end
      if (cfg_we && cfg_sel == 3'd4 && int'(cfg_obj) < NOBJ) begin
        cn[cfg_obj] = cfg_wdata[0];
        cl[cfg_obj] = cfg_wdata[1];
      end
      m_nd   = (m_nd & ~cn) | setv;
      m_lost = (m_lost & ~cl) | (setv & nd_old);
      p_vld = 0;
      if (frm_valid) begin
        for (int i = 0; i < NOBJ; i++) begin
          logic [28:0] mk;
          mk = (i == NOBJ - 1) ? (m_gm & m_lm) : m_gm;
          if (!frm_ext) mk = mk & 29'h1FFC_0000;
          if (!p_vld && m_vld[i] && m_rx[i] && (m_ext[i] == frm_ext) &&
              (((m_id[i] ^ frm_id) & mk) == '0)) begin
            p_vld = 1; p_idx = i;
          end
        end
        p_dlc = frm_dlc; p_data = frm_data;
      end
      if (cfg_we) begin
        if (int'(cfg_obj) < NOBJ) begin
          if (cfg_sel == 3'd0) m_id[cfg_obj] = cfg_wdata;
          if (cfg_sel == 3'd1) begin
            m_vld[cfg_obj] = cfg_wdata[0];
            m_rx[cfg_obj]  = (int'(cfg_obj) == NOBJ - 1) ? 1'b1 : cfg_wdata[1];
            m_ext[cfg_obj] = cfg_wdata[2];
          end
        end
        if (cfg_sel == 3'd2) m_gm = cfg_wdata;
        if (cfg_sel == 3'd3) m_lm = cfg_wdata;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  bit run = 0;
  always @(negedge clk) begin
    if (run && !rst) begin
      chk("R8 hit", 64'(hit), 64'(m_hit));
      chk("R8 irq", 64'(rx_irq), 64'(m_hit));
      chk("R4 idx", 64'(hit_idx), 64'(m_idx));
      chk("R6 new_data", 64'(new_data), 64'(m_nd));
      chk("R7 msg_lost", 64'(msg_lost), 64'(m_lost));
    end
  end

  function automatic logic [28:0] std_id(int v);
    return 29'(v) << 18;
  endfunction

  task automatic cfg(logic [2:0] s, int o, logic [28:0] d);
    cfg_we = 1; cfg_sel = s; cfg_obj = 4'(o); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_exp(logic [28:0] id, logic ext, logic [3:0] dlc,
                          logic [63:0] d, bit exp_hit, int exp_idx);
    frm_valid = 1; frm_id = id; frm_ext = ext; frm_dlc = dlc; frm_data = d;
    @(negedge clk);
    frm_valid = 0;
    chk("R8 early", 64'(hit), 64'd0);
    @(negedge clk);
    chk(exp_hit ? "R8 hit" : "R9 nohit", 64'(hit), 64'(exp_hit));
    if (exp_hit) chk("R4 winner", 64'(hit_idx), 64'(exp_idx));
    @(negedge clk);
    chk("R8 pulse", 64'(hit), 64'd0);
  endtask

  task automatic check_rd(int k);
    rd_obj = 4'(k);
    @(negedge clk);
    chk("R11 dlc", 64'(rd_dlc), 64'(m_dlc[k]));
    chk("R11 data", rd_data & m_kn[k], m_mem[k] & m_kn[k]);
  endtask

  localparam logic [63:0] DA = 64'h8877_6655_4433_2211;
  localparam logic [63:0] DB = 64'h0102_0304_0506_A5C3;

  initial begin
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_obj = 0; cfg_wdata = 0;
    frm_valid = 0; frm_id = 0; frm_ext = 0; frm_dlc = 0; frm_data = 0; rd_obj = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    run = 1;
    chk("R1 nd", 64'(new_data), 64'd0);
    chk("R1 lost", 64'(msg_lost), 64'd0);
    chk("R1 hit", 64'(hit), 64'd0);
    chk("R1 irq", 64'(rx_irq), 64'd0);
    send_exp(std_id(0), 0, 1, DA, 0, 0);          // R1 all invalid

    cfg(3'd0, 0, std_id(12'h123));
    cfg(3'd1, 0, 29'd3);
    send_exp(std_id(12'h123), 0, 3, DA, 1, 0);    // R2 basic match
    chk("R6 nd0", 64'(new_data[0]), 64'd1);
    check_rd(0);
    chk("R6 bytes", rd_data & 64'hFF_FFFF, 64'h33_2211);

    send_exp(std_id(12'h123) | 29'h1_5555, 0, 8, DB, 1, 0);  // R3 low bits ignored
    chk("R7 lost0", 64'(msg_lost[0]), 64'd1);
    check_rd(0);

    cfg(3'd4, 0, 29'd3);                          // R10 clear
    chk("R10 nd0", 64'(new_data[0]), 64'd0);
    chk("R10 lost0", 64'(msg_lost[0]), 64'd0);

    send_exp(std_id(12'h123), 1, 2, DA, 0, 0);    // R2 frame type mismatch
    cfg(3'd0, 1, std_id(12'h0AA));
    cfg(3'd1, 1, 29'd1);
    send_exp(std_id(12'h0AA), 0, 2, DA, 0, 0);    // R2 transmit object ignored

    cfg(3'd0, 3, std_id(12'h200)); cfg(3'd1, 3, 29'd3);
    cfg(3'd0, 6, std_id(12'h200)); cfg(3'd1, 6, 29'd3);
    send_exp(std_id(12'h200), 0, 2, DA, 1, 3);    // R4 lowest wins
    cfg(3'd1, 3, 29'd0);
    send_exp(std_id(12'h200), 0, 2, DA, 1, 6);    // R4 next in line
    cfg(3'd1, 3, 29'd3);

    cfg(3'd2, 0, 29'h1FFB_FFFF);                  // R2 global mask bit 18 don't care
    send_exp(std_id(12'h122), 0, 1, DB, 1, 0);
    cfg(3'd2, 0, 29'h1FFF_FFFF);

    cfg(3'd0, 14, 29'h1ABC_DE0);
    cfg(3'd1, 14, 29'd5);                         // R5 direction bit ignored
    cfg(3'd3, 0, 29'h1FFF_FFF0);
    send_exp(29'h1ABC_DE7, 1, 4, DA, 1, 14);      // R5 group mask
    cfg(3'd0, 5, 29'h1ABC_DE7); cfg(3'd1, 5, 29'd7);
    send_exp(29'h1ABC_DE7, 1, 4, DB, 1, 5);       // R4 object 14 last
    send_exp(29'h1ABC_DEA, 1, 4, DB, 1, 14);
    send_exp(29'h1ABC_DF0, 1, 4, DB, 0, 0);       // R5 bit 4 still compared
    cfg(3'd2, 0, 29'h1FFF_FFEF);
    send_exp(29'h1ABC_DF0, 1, 4, DA, 1, 14);      // R5 AND of both masks
    cfg(3'd2, 0, 29'h1FFF_FFFF);

    send_exp(std_id(12'h200), 0, 4'd12, DA, 1, 3); // R6 dlc above 8
    check_rd(3);
    chk("R6 full", rd_data, DA);
    chk("R6 dlc", 64'(rd_dlc), 64'd12);
    send_exp(std_id(12'h200), 0, 2, DB, 1, 3);
    check_rd(3);
    chk("R6 keep", rd_data, {DA[63:16], DB[15:0]});

    begin
      logic [14:0] nd_s, lost_s;
      nd_s = new_data; lost_s = msg_lost;
      send_exp(std_id(12'h7FF), 0, 8, DA, 0, 0);  // R9 no match
      chk("R9 nd", 64'(new_data), 64'(nd_s));
      chk("R9 lost", 64'(msg_lost), 64'(lost_s));
      check_rd(3);
      chk("R9 data", rd_data, {DA[63:16], DB[15:0]});
    end

    frm_valid = 1; frm_id = std_id(12'h123); frm_ext = 0; frm_dlc = 1; frm_data = DA;
    @(negedge clk);
    frm_id = std_id(12'h200); frm_data = DB;
    @(negedge clk);
    frm_valid = 0;
    chk("R8 b2b first", 64'({hit, hit_idx}), 64'({1'b1, 4'd0}));
    @(negedge clk);
    chk("R8 b2b second", 64'({hit, hit_idx}), 64'({1'b1, 4'd3}));
    @(negedge clk);
    chk("R8 b2b end", 64'(hit), 64'd0);

    cfg(3'd4, 3, 29'd1);
    chk("R10 nd only", 64'({new_data[3], msg_lost[3]}), 64'({1'b0, 1'b1}));
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule